// File: doc/BRIEF.md
# Pipelined Row-Column 8x8 Forward DCT

This block computes the two-dimensional forward discrete cosine transform of one 8x8 tile of signed samples. Samples arrive one per cycle over a valid/ready write port in raster order (row 0 left to right, then row 1, and so on). Every time a row of eight samples is complete, it is sent through a single shared seven-register 1D transform pipeline. That pipeline produces the four even-frequency results of the row in one cycle and the four odd-frequency results in the next. These intermediate results, with three fractional guard bits, fill an 8x8 corner-turn store.

Once all eight rows sit in the store, the same pipeline runs the column pass. It takes one column vector from the store per two cycles, again even half then odd half. The final coefficients land in an output buffer. They then stream out in row-major order through a valid/ready read port. A one-cycle completion pulse follows the last coefficient, and the block is then ready for the next tile.

Top module: `dct8x8_rowcol`

## Requirements
- R1: While reset is held and on its release, in_ready is 1, out_valid is 0 and done is 0.
- R2: The k-th accepted sample (k = 0..63, accepted when in_valid and in_ready are both 1) is tile element row k/8, column k%8, as 8-bit two's complement. After the 64th acceptance, in_ready stays 0 until done has pulsed, and in_ready is never 1 while out_valid is 1.
- R3: The 64 outputs leave in the order index = u*8 + v, as 12-bit two's complement. Output (u,v) lies within 1.0 of Y(u,v) = 0.25*a(u)*a(v)*sum over x,y of f(x,y)*cos((2x+1)u*pi/16)*cos((2y+1)v*pi/16). Here f(x,y) is row x, column y, and a(0) = 1/sqrt(2), a(n>0) = 1.
- R4: Within each 8-point pass, the shared pipeline delivers the even-index half (0,2,4,6) of a vector and then its odd-index half (1,3,5,7) on the very next cycle. Coefficients with an odd u or odd v meet the R3 tolerance like the rest.
- R5: No coefficient is presented (out_valid stays 0) while a tile is being written. The column pass starts only after all eight row results are stored, and the row and column passes never feed the pipeline in the same cycle.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value on the next cycle.
- R7: done is a single-cycle pulse in the cycle after the handshake of the 64th coefficient. In that cycle in_ready is already 1 again.
- R8: out_valid rises no more than 40 clock cycles after the edge that accepts the 64th sample.
- R9: Full-scale tiles do not wrap. A constant tile of -128 yields a DC term within 1 of -1024, a constant tile of 127 yields a DC term within 1 of 1016, and every AC term stays within 1 of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample on in_data is offered |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_data | input | 8 | Signed input sample, raster order |
| out_valid | output | 1 | Coefficient on out_data is offered |
| out_ready | input | 1 | Consumer takes the offered coefficient |
| out_data | output | 12 | Signed coefficient, row-major order |
| done | output | 1 | One-cycle pulse after the last coefficient is taken |

## Verification
The embedded properties assume only that reset is applied before the first transfer. in_valid may be raised in any state and out_ready may fall at any cycle, because the block gates both through its own in_ready and out_valid. The stimulus reaches the signed 8-bit extremes, impulse, ramp, checkerboard and random tiles, and it inserts idle cycles between samples. It also throttles out_ready at random on some tiles, so the hold, completion and ordering properties are exercised under stalls as well as at full rate.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int PTS   = 8;
  localparam int HALF  = PTS / 2;
  localparam int IW    = $clog2(PTS);
  localparam int CBITS = 12;

  typedef enum logic [2:0] {
    ST_LOAD, ST_ROWS, ST_COLS, ST_DRAIN, ST_OUT
  } seq_t;

  // cos(i*pi/16) scaled by 2^CBITS, any integer i >= 0
  function automatic int cos_q(input int idx);
    int i;
    int s;
    int v;
    i = idx % 32;
    s = 1;
    if (i > 16) i = 32 - i;
    if (i > 8) begin
      i = 16 - i;
      s = -1;
    end
    case (i)
      0: v = 4096;
      1: v = 4017;
      2: v = 3784;
      3: v = 3406;
      4: v = 2896;
      5: v = 2276;
      6: v = 1567;
      7: v = 799;
      default: v = 0;
    endcase
    return s * v;
  endfunction

  // weight of input n (0..3, folded) for output frequency k
  function automatic int w_q(input int k, input int n);
    if (k == 0) return cos_q(4);
    return cos_q((2 * n + 1) * k);
  endfunction
endpackage

// File: rtl/dct_row_stage.sv
module dct_row_stage import dct_pkg::*; #(
  parameter int IN_W = 8,
  parameter int DW   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic signed [IN_W-1:0] smp,
  input  logic [IW-1:0]        smp_col,
  input  logic [IW-1:0]        smp_row,
  output logic                 go,
  output logic                 phase,
  output logic [IW-1:0]        row,
  output logic signed [DW-1:0] vec [PTS]
);
  logic signed [IN_W-1:0] hold [PTS-1];
  logic pend, ph;

  always_ff @(posedge clk) begin
    if (smp_vld) begin
      if (smp_col != IW'(PTS - 1)) begin
        hold[smp_col] <= smp;
      end else begin
        for (int i = 0; i < PTS - 1; i++) vec[i] <= DW'(hold[i]);
        vec[PTS-1] <= DW'(smp);
        row <= smp_row;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      ph   <= 1'b0;
    end else begin
      if (smp_vld && smp_col == IW'(PTS - 1)) pend <= 1'b1;
      else if (pend && ph) pend <= 1'b0;
      if (pend) ph <= ~ph;
    end
  end

  assign go    = pend;
  assign phase = ph;

  p_two_halves_r4: assert property (@(posedge clk) disable iff (rst)
    (go && !phase) |=> (go && phase));
endmodule

// File: rtl/dct_engine.sv
module dct_engine import dct_pkg::*; #(
  parameter int DW   = 16,
  parameter int FRAC = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic                 in_phase,
  input  logic                 in_pass,
  input  logic [IW-1:0]        in_idx,
  input  logic signed [DW-1:0] in_vec [PTS],
  output logic                 out_vld,
  output logic                 out_phase,
  output logic                 out_pass,
  output logic [IW-1:0]        out_idx,
  output logic signed [DW-1:0] out_res [HALF]
);
  localparam int NST    = 7;
  localparam int VW     = DW + 1;
  localparam int PW     = DW + 16;
  localparam int SH_ROW = CBITS + 1 - FRAC;
  localparam int SH_COL = CBITS + 1 + FRAC;
  localparam logic signed [PW-1:0] RND_ROW = PW'(1) <<< (SH_ROW - 1);
  localparam logic signed [PW-1:0] RND_COL = PW'(1) <<< (SH_COL - 1);

  logic [NST-1:0]         vld, ph, ps;
  logic [NST-1:0][IW-1:0] ix;

  logic signed [DW-1:0] x  [PTS];
  logic signed [VW-1:0] v  [HALF];
  logic signed [PW-1:0] p  [HALF][HALF];
  logic signed [PW-1:0] q  [HALF][2];
  logic signed [PW-1:0] t  [HALF];
  logic signed [DW-1:0] r  [HALF];
  logic signed [DW-1:0] o  [HALF];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[NST-2:0], in_vld};
    ph <= {ph[NST-2:0], in_phase};
    ps <= {ps[NST-2:0], in_pass};
    ix <= {ix[NST-2:0], in_idx};
  end

  always_ff @(posedge clk) begin
    x <= in_vec;
    for (int n = 0; n < HALF; n++) begin
      v[n] <= ph[0] ? VW'(x[n]) - VW'(x[PTS-1-n])
                    : VW'(x[n]) + VW'(x[PTS-1-n]);
    end
    for (int j = 0; j < HALF; j++) begin
      for (int n = 0; n < HALF; n++) begin
        p[j][n] <= PW'(v[n]) *
                   PW'(ph[1] ? w_q(2 * j + 1, n) : w_q(2 * j, n));
      end
      q[j][0] <= p[j][0] + p[j][1];
      q[j][1] <= p[j][2] + p[j][3];
      t[j]    <= q[j][0] + q[j][1];
      r[j]    <= ps[4] ? DW'((t[j] + RND_COL) >>> SH_COL)
                       : DW'((t[j] + RND_ROW) >>> SH_ROW);
      o[j]    <= r[j];
    end
  end

  assign out_vld   = vld[NST-1];
  assign out_phase = ph[NST-1];
  assign out_pass  = ps[NST-1];
  assign out_idx   = ix[NST-1];
  assign out_res   = o;

  p_even_then_odd_r4: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_phase) |=> (out_vld && out_phase && $stable(out_idx) && $stable(out_pass)));
endmodule

// File: rtl/dct_transpose.sv
module dct_transpose import dct_pkg::*; #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic                 wr_phase,
  input  logic [IW-1:0]        wr_row,
  input  logic signed [DW-1:0] wr_data [HALF],
  input  logic                 rd_en,
  input  logic [IW-1:0]        rd_col,
  output logic signed [DW-1:0] rd_vec [PTS],
  output logic                 rows_full
);
  logic signed [DW-1:0] mem [PTS][PTS];
  logic [IW:0] rows;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int j = 0; j < HALF; j++) begin
        mem[wr_row][IW'(2 * j + int'(wr_phase))] <= wr_data[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)              rows <= '0;
    else if (wr_en && wr_phase)  rows <= rows + 1'b1;
  end

  assign rows_full = (rows == (IW + 1)'(PTS));

  always_comb begin
    for (int i = 0; i < PTS; i++) rd_vec[i] = mem[i][rd_col];
  end

  p_cols_after_rows_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> rows_full);
  p_no_extra_rows_r5: assert property (@(posedge clk) disable iff (rst)
    rows_full |-> !(wr_en && !clr));
endmodule

// File: rtl/dct8x8_rowcol.sv
module dct8x8_rowcol import dct_pkg::*; #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 12,
  parameter int MID_W = 16,
  parameter int FRAC  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_data,
  output logic                    done
);
  localparam int NSMP = PTS * PTS;
  localparam int SW   = $clog2(NSMP);
  localparam int CW   = $clog2(2 * PTS);
  localparam logic signed [MID_W-1:0] OMAX = MID_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [MID_W-1:0] OMIN = -OMAX - 1;

  seq_t             st;
  logic [SW-1:0]    scnt;
  logic [CW-1:0]    ccnt;
  logic [IW:0]      cdone;
  logic [SW:0]      optr;
  logic             accept, col_go;

  logic                  rs_go, rs_ph;
  logic [IW-1:0]         rs_row;
  logic signed [MID_W-1:0] rs_vec [PTS];
  logic signed [MID_W-1:0] tp_vec [PTS];
  logic                  rows_full;

  logic                  e_vld, e_phase, e_pass;
  logic [IW-1:0]         e_idx;
  logic signed [MID_W-1:0] e_vec [PTS];
  logic                  r_vld, r_phase, r_pass;
  logic [IW-1:0]         r_idx;
  logic signed [MID_W-1:0] r_res [HALF];
  logic signed [OUT_W-1:0] r_sat [HALF];

  logic signed [OUT_W-1:0] obuf [NSMP];

  assign in_ready = (st == ST_LOAD);
  assign accept   = in_valid && in_ready;
  assign col_go   = (st == ST_COLS);

  dct_row_stage #(.IN_W(IN_W), .DW(MID_W)) u_stage (
    .clk(clk), .rst(rst), .smp_vld(accept), .smp(in_data),
    .smp_col(scnt[IW-1:0]), .smp_row(scnt[SW-1:IW]),
    .go(rs_go), .phase(rs_ph), .row(rs_row), .vec(rs_vec)
  );

  always_comb begin
    e_vld   = rs_go || col_go;
    e_pass  = col_go;
    e_phase = col_go ? ccnt[0] : rs_ph;
    e_idx   = col_go ? ccnt[CW-1:1] : rs_row;
    for (int i = 0; i < PTS; i++) e_vec[i] = col_go ? tp_vec[i] : rs_vec[i];
  end

  dct_engine #(.DW(MID_W), .FRAC(FRAC)) u_engine (
    .clk(clk), .rst(rst), .in_vld(e_vld), .in_phase(e_phase), .in_pass(e_pass),
    .in_idx(e_idx), .in_vec(e_vec), .out_vld(r_vld), .out_phase(r_phase),
    .out_pass(r_pass), .out_idx(r_idx), .out_res(r_res)
  );

  dct_transpose #(.DW(MID_W)) u_corner (
    .clk(clk), .rst(rst), .clr(done), .wr_en(r_vld && !r_pass), .wr_phase(r_phase),
    .wr_row(r_idx), .wr_data(r_res), .rd_en(col_go), .rd_col(ccnt[CW-1:1]),
    .rd_vec(tp_vec), .rows_full(rows_full)
  );

  always_comb begin
    for (int j = 0; j < HALF; j++) begin
      if (r_res[j] > OMAX)      r_sat[j] = OMAX[OUT_W-1:0];
      else if (r_res[j] < OMIN) r_sat[j] = OMIN[OUT_W-1:0];
      else                      r_sat[j] = r_res[j][OUT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (r_vld && r_pass) begin
      for (int j = 0; j < HALF; j++) begin
        obuf[{IW'(2 * j + int'(r_phase)), r_idx}] <= r_sat[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_LOAD;
      scnt      <= '0;
      ccnt      <= '0;
      cdone     <= '0;
      optr      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (r_vld && r_pass && r_phase) cdone <= cdone + 1'b1;
      case (st)
        ST_LOAD: if (accept) begin
          scnt <= scnt + 1'b1;
          if (scnt == SW'(NSMP - 1)) st <= ST_ROWS;
        end
        ST_ROWS: if (rows_full) begin
          st   <= ST_COLS;
          ccnt <= '0;
        end
        ST_COLS: begin
          ccnt <= ccnt + 1'b1;
          if (ccnt == CW'(2 * PTS - 1)) st <= ST_DRAIN;
        end
        ST_DRAIN: if (cdone == (IW + 1)'(PTS)) begin
          st   <= ST_OUT;
          optr <= '0;
        end
        ST_OUT: if (!out_valid || out_ready) begin
          if (optr[SW]) begin
            out_valid <= 1'b0;
            done      <= 1'b1;
            cdone     <= '0;
            st        <= ST_LOAD;
          end else begin
            out_data  <= obuf[optr[SW-1:0]];
            out_valid <= 1'b1;
            optr      <= optr + 1'b1;
          end
        end
        default: st <= ST_LOAD;
      endcase
    end
  end

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_done_after_read_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready));
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  p_one_user_r5: assert property (@(posedge clk) disable iff (rst)
    !(rs_go && col_go));
endmodule

// File: tb/sim_dct8x8_rowcol.sv
module sim_dct8x8_rowcol;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [7:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [11:0] out_data;
  logic done;

  int checks = 0;
  int errors = 0;
  real   expq[$];
  string tagq[$];
  int    blk[64];
  bit    bp_mode = 1'b0;
  bit    done_due = 1'b0;
  bit    hold_pend = 1'b0;
  logic signed [11:0] hold_val;

  always #10 clk = ~clk;

  dct8x8_rowcol u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // reference model: orthonormal 2D DCT in floating point, pushed to the scoreboard
  task automatic push_ref(input string tag);
    for (int u = 0; u < 8; u++) begin
      for (int v = 0; v < 8; v++) begin
        real s;
        real au;
        real av;
        s = 0.0;
        for (int x = 0; x < 8; x++)
          for (int y = 0; y < 8; y++)
            s += real'(blk[x*8+y]) * $cos((2*x+1)*u*PI/16.0) * $cos((2*y+1)*v*PI/16.0);
        au = (u == 0) ? 1.0 / $sqrt(2.0) : 1.0;
        av = (v == 0) ? 1.0 / $sqrt(2.0) : 1.0;
        expq.push_back(0.25 * au * av * s);
        tagq.push_back(((u % 2) == 1 || (v % 2) == 1) ? {tag, " R4"} : tag);
      end
    end
  endtask

  // driver: raster-order samples, optional idle gaps, then latency check
  task automatic send_block(input string tag, input bit gaps);
    int lat;
    bit ok;
    push_ref(tag);
    for (int k = 0; k < 64; k++) begin
      @(posedge clk);
      #1;
      in_valid = 1'b1;
      in_data  = 8'(blk[k]);
      do begin
        @(negedge clk);
        ok = in_ready;
        if (out_valid) chk(1'b0, $sformatf("R5 out_valid during load actual=1 expected=0"));
        @(posedge clk);
      end while (!ok);
      #1;
      in_valid = 1'b0;
      if (gaps && (k % 5 == 4)) @(posedge clk);
    end
    lat = 0;
    @(negedge clk);
    chk(in_ready == 1'b0, $sformatf("R2 in_ready after 64th sample actual=%0b expected=0", in_ready));
    while (!out_valid && lat < 60) begin
      lat++;
      @(negedge clk);
    end
    chk(lat <= 40, $sformatf("R8 cycles to first coefficient actual=%0d expected<=40", lat + 1));
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? ($urandom_range(2) != 0) : 1'b1;
  end

  // monitor: scoreboard compare plus hold and completion checks
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend)
        chk(out_valid && out_data == hold_val,
            $sformatf("R6 stalled output actual=%0d/%0b expected=%0d/1", out_data, out_valid, hold_val));
      hold_pend = out_valid && !out_ready;
      hold_val  = out_data;
      if (done_due) begin
        chk(done == 1'b1 && in_ready == 1'b1,
            $sformatf("R7 done/in_ready after last read actual=%0b/%0b expected=1/1", done, in_ready));
        done_due = 1'b0;
      end else if (done) begin
        chk(1'b0, "R7 unexpected done actual=1 expected=0");
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, $sformatf("R3 extra coefficient actual=%0d expected=none", out_data));
        end else begin
          real   e;
          real   d;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          d = real'(out_data) - e;
          if (d < 0.0) d = -d;
          chk(d <= 1.0, $sformatf("%s coefficient %0d actual=%0d expected=%0.3f",
                                  t, 63 - expq.size(), out_data, e));
          if (expq.size() == 0) done_due = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && done === 1'b0,
        $sformatf("R1 reset state actual=%0b%0b%0b expected=100", in_ready, out_valid, done));
    @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && done === 1'b0,
        $sformatf("R1 after release actual=%0b%0b%0b expected=100", in_ready, out_valid, done));

    for (int k = 0; k < 64; k++) blk[k] = 0;
    blk[0] = 100;
    send_block("R3", 1'b0);

    for (int k = 0; k < 64; k++) blk[k] = k * 4 - 128;
    send_block("R3", 1'b1);

    for (int k = 0; k < 64; k++) blk[k] = (((k / 8) + (k % 8)) % 2 == 1) ? 100 : -100;
    send_block("R3", 1'b0);

    for (int k = 0; k < 64; k++) blk[k] = 127;
    send_block("R9", 1'b0);

    for (int k = 0; k < 64; k++) blk[k] = -128;
    bp_mode = 1'b1;
    send_block("R9", 1'b0);

    for (int b = 0; b < 3; b++) begin
      for (int k = 0; k < 64; k++) blk[k] = int'($urandom_range(255)) - 128;
      send_block("R3", b[0]);
    end

    for (int k = 0; k < 64; k++) blk[k] = (k % 2 == 0) ? 127 : -128;
    bp_mode = 1'b0;
    send_block("R9", 1'b1);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule